// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Accumulator Processor

This block turns the operand bytes of an instruction into the 16-bit memory address that the instruction works on. It covers a small accumulator machine's addressing modes: no operand, 8-bit and 16-bit immediate, full 16-bit absolute, page-zero short, index-register-plus-offset, and program-counter-relative branch. Each clock, the decoder presents a mode code, the bytes that follow the opcode, the current index register and the address of the opcode. One clock later the block presents the operand address, a flag that marks it as a real memory reference, the address of the following byte for two-byte operand transfers, and the number of bytes by which the program counter moves past the instruction.

An index offset is always treated as unsigned, so it reaches 255 bytes forward. A branch offset is treated as signed and is measured from the instruction that follows the two-byte branch. There is no indirect mode: an indexed reference with offset zero points straight at the index register's value. All address arithmetic wraps around the 64 KiB space without error.

Top module: `eff_addr_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next edge clears `ea_valid`, `ea_addr`, `ea_pair` and `pc_step` to zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge (one cycle of latency). `ea_valid` is 1 for mode codes 1 through 6 and 0 otherwise.
- R3: Mode code 3 (absolute) gives `ea_addr = {byte2, byte3}`, with byte2 as the high byte.
- R4: Mode code 4 (page zero) gives `ea_addr = {8'h00, byte2}`.
- R5: Mode code 5 (indexed) gives `ea_addr = (index_reg + byte2) mod 2^16`, with byte2 zero-extended (0..255). Offset 0 yields index_reg.
- R6: Mode code 6 (relative) gives `ea_addr = (pc + 2 + sext(byte2)) mod 2^16`, with byte2 a signed offset from -128 to +127.
- R7: Mode codes 1 (8-bit immediate) and 2 (16-bit immediate) give `ea_addr = (pc + 1) mod 2^16`, the byte after the opcode.
- R8: Mode code 0 (no operand) and reserved code 7 give `ea_valid = 0`, `ea_addr = 0` and `ea_pair = 0`, whatever the other inputs are.
- R9: When `ea_valid` is 1, `ea_pair = (ea_addr + 1) mod 2^16`, including the wrap from 16'hFFFF to 16'h0000.
- R10: `pc_step` is 1 for codes 0 and 7; 2 for codes 1, 4, 5 and 6; and 3 for codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Addressing mode code |
| byte2 | input | 8 | First byte after the opcode |
| byte3 | input | 8 | Second byte after the opcode |
| index_reg | input | 16 | Index register value |
| pc | input | 16 | Address of the opcode |
| ea_valid | output | 1 | Address is a memory reference |
| ea_addr | output | 16 | Effective address (high byte of a 16-bit operand) |
| ea_pair | output | 16 | Address of the following byte (low byte of a 16-bit operand) |
| pc_step | output | 2 | Instruction length in bytes |

## Verification
The only state in the block is its single output register stage. A fault in that stage, or in the mode selection ahead of it, shows up at the ports on the very next cycle as a wrong address, pair address, length or valid flag for the vector presented one clock earlier. The riskiest spots are sign versus zero extension of the offset, the +2 bias on branches, and the carry and wrap at 16'hFFFF. The comparison at every clock therefore targets offsets 0x00, 0x7F, 0x80 and 0xFF and bases near both ends of the address space, so that a single wrong bit becomes visible within one cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int STEP_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_NONE  = 3'd0,
        AM_IMM8  = 3'd1,
        AM_IMM16 = 3'd2,
        AM_ABS   = 3'd3,
        AM_ZPG   = 3'd4,
        AM_IDX   = 3'd5,
        AM_REL   = 3'd6,
        AM_RSVD  = 3'd7
    } amode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } ea_res_t;

    function automatic logic [STEP_W-1:0] step_of(amode_e m);
        logic [STEP_W-1:0] s;
        case (m)
            AM_NONE, AM_RSVD: s = 2'd1;
            AM_ABS, AM_IMM16: s = 2'd3;
            default:          s = 2'd2;
        endcase
        return s;
    endfunction

    function automatic logic is_memref(amode_e m);
        return (m != AM_NONE) && (m != AM_RSVD);
    endfunction

endpackage

// File: rtl/eag_offset_add.sv
module eag_offset_add #(
    parameter int AW         = 16,
    parameter int OW         = 8,
    parameter bit SIGNED_OFS = 1'b0,
    parameter int BIAS       = 0
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] sum
);
    localparam int PADW = AW - OW;
    localparam logic [AW-1:0] BIAS_V = AW'(BIAS);

    logic [AW-1:0] ofs_ext;

    generate
        if (SIGNED_OFS) begin : g_sext
            assign ofs_ext = {{PADW{ofs[OW-1]}}, ofs};
        end else begin : g_zext
            assign ofs_ext = {{PADW{1'b0}}, ofs};
        end
    endgenerate

    assign sum = base + ofs_ext + BIAS_V;
endmodule

// File: rtl/eag_mode_sel.sv
module eag_mode_sel
    import eag_pkg::*;
(
    input  amode_e            mode,
    input  logic [BYTE_W-1:0] byte2,
    input  logic [BYTE_W-1:0] byte3,
    input  logic [ADDR_W-1:0] index_reg,
    input  logic [ADDR_W-1:0] pc,
    output ea_res_t           res
);
    localparam logic [BYTE_W-1:0] ZERO_OFS = '0;

    logic [ADDR_W-1:0] idx_sum;
    logic [ADDR_W-1:0] rel_sum;
    logic [ADDR_W-1:0] imm_sum;

    eag_offset_add #(.AW(ADDR_W), .OW(BYTE_W), .SIGNED_OFS(1'b0), .BIAS(0)) u_idx_add (
        .base(index_reg), .ofs(byte2), .sum(idx_sum)
    );

    eag_offset_add #(.AW(ADDR_W), .OW(BYTE_W), .SIGNED_OFS(1'b1), .BIAS(2)) u_rel_add (
        .base(pc), .ofs(byte2), .sum(rel_sum)
    );

    eag_offset_add #(.AW(ADDR_W), .OW(BYTE_W), .SIGNED_OFS(1'b0), .BIAS(1)) u_imm_add (
        .base(pc), .ofs(ZERO_OFS), .sum(imm_sum)
    );

    always_comb begin
        res.valid = is_memref(mode);
        case (mode)
            AM_IMM8, AM_IMM16: res.addr = imm_sum;
            AM_ABS:            res.addr = {byte2, byte3};
            AM_ZPG:            res.addr = {{(ADDR_W-BYTE_W){1'b0}}, byte2};
            AM_IDX:            res.addr = idx_sum;
            AM_REL:            res.addr = rel_sum;
            default:           res.addr = '0;
        endcase
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [BYTE_W-1:0] byte2,
    input  logic [BYTE_W-1:0] byte3,
    input  logic [ADDR_W-1:0] index_reg,
    input  logic [ADDR_W-1:0] pc,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [ADDR_W-1:0] ea_pair,
    output logic [STEP_W-1:0] pc_step
);
    localparam logic [BYTE_W-1:0] ZERO_OFS = '0;

    amode_e            mode_e;
    ea_res_t           res_c;
    logic [ADDR_W-1:0] pair_c;

    assign mode_e = amode_e'(mode);

    eag_mode_sel u_sel (
        .mode(mode_e), .byte2(byte2), .byte3(byte3),
        .index_reg(index_reg), .pc(pc), .res(res_c)
    );

    eag_offset_add #(.AW(ADDR_W), .OW(BYTE_W), .SIGNED_OFS(1'b0), .BIAS(1)) u_pair_add (
        .base(res_c.addr), .ofs(ZERO_OFS), .sum(pair_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid <= 1'b0;
            ea_addr  <= '0;
            ea_pair  <= '0;
            pc_step  <= '0;
        end else begin
            ea_valid <= res_c.valid;
            ea_addr  <= res_c.valid ? res_c.addr : '0;
            ea_pair  <= res_c.valid ? pair_c : '0;
            pc_step  <= step_of(mode_e);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!ea_valid && ea_addr == '0 && ea_pair == '0 && pc_step == '0));

    // R3
    abs_concat_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_ABS) |=> (ea_valid && ea_addr == {$past(byte2), $past(byte3)}));

    // R4
    zpg_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_ZPG) |=> (ea_addr[ADDR_W-1:BYTE_W] == '0));

    // R8
    none_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_NONE || mode == AM_RSVD) |=> (!ea_valid && ea_pair == '0));

    // R9
    pair_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (ea_pair == ea_addr + 16'd1));

    // R10
    step_len_chk: assert property (@(posedge clk) disable iff (rst)
        ea_valid |-> (pc_step == 2'd2 || pc_step == 2'd3));
endmodule

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [7:0]  byte2 = '0;
    logic [7:0]  byte3 = '0;
    logic [15:0] index_reg = '0;
    logic [15:0] pc = '0;
    logic        ea_valid;
    logic [15:0] ea_addr;
    logic [15:0] ea_pair;
    logic [1:0]  pc_step;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state: expected outputs for the vector last driven
    bit   have_prev = 0;
    int   x_valid, x_addr, x_pair, x_step;
    string x_tag;

    always #2.5 clk = ~clk;

    eff_addr_gen i_eff_addr_gen (
        .clk(clk), .rst(rst), .mode(mode), .byte2(byte2), .byte3(byte3),
        .index_reg(index_reg), .pc(pc), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .ea_pair(ea_pair), .pc_step(pc_step)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_prev();
        check("R2", "valid", int'(ea_valid), x_valid);
        check(x_tag, "addr", int'(ea_addr), x_addr);
        check(x_valid ? "R9" : "R8", "pair", int'(ea_pair), x_pair);
        check("R10", "step", int'(pc_step), x_step);
    endtask

    task automatic apply(int m, int b2, int b3, int ix, int p);
        int sb;
        @(negedge clk);
        if (have_prev) compare_prev();
        mode = 3'(m); byte2 = 8'(b2); byte3 = 8'(b3);
        index_reg = 16'(ix); pc = 16'(p);
        sb = (b2 >= 128) ? b2 - 256 : b2;
        x_valid = (m >= 1 && m <= 6) ? 1 : 0;
        case (m)
            1, 2: begin x_addr = (p + 1) & 65535;        x_tag = "R7"; end
            3:    begin x_addr = b2 * 256 + b3;          x_tag = "R3"; end
            4:    begin x_addr = b2;                     x_tag = "R4"; end
            5:    begin x_addr = (ix + b2) & 65535;      x_tag = "R5"; end
            6:    begin x_addr = (p + 2 + sb) & 65535;   x_tag = "R6"; end
            default: begin x_addr = 0;                   x_tag = "R8"; end
        endcase
        x_pair = x_valid ? ((x_addr + 1) & 65535) : 0;
        if (m == 0 || m == 7) x_step = 1;
        else if (m == 2 || m == 3) x_step = 3;
        else x_step = 2;
        have_prev = 1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mode = 3'd3; byte2 = 8'hAB; byte3 = 8'hCD; pc = 16'h1234; index_reg = 16'h4321;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "valid", int'(ea_valid), 0);
        check("R1", "addr", int'(ea_addr), 0);
        check("R1", "pair", int'(ea_pair), 0);
        check("R1", "step", int'(pc_step), 0);
        rst = 1'b0;

        // directed corners
        apply(3, 8'h12, 8'h34, 0, 16'h0100);       // R3
        apply(3, 8'hFF, 8'hFF, 0, 16'h0100);       // R3, R9 pair wrap
        apply(4, 8'h7E, 8'h55, 16'hFFFF, 16'h2000);// R4
        apply(4, 8'hFF, 8'h00, 0, 0);              // R4, pair 0100
        apply(5, 8'h00, 8'h99, 16'hBEEF, 0);       // R5 offset 0
        apply(5, 8'hFF, 8'h00, 16'hFFFF, 0);       // R5 wrap -> 00FE
        apply(5, 8'h80, 8'h00, 16'h1000, 0);       // R5 unsigned 0x80
        apply(6, 8'h05, 8'h00, 0, 16'h0200);       // R6 +5 -> 0207
        apply(6, 8'h80, 8'h00, 0, 16'h0010);       // R6 -128 wraps
        apply(6, 8'h7F, 8'h00, 0, 16'hFFFE);       // R6 +127 wraps
        apply(6, 8'hFE, 8'h00, 0, 16'h0300);       // R6 -2 -> self
        apply(1, 8'h11, 8'h22, 0, 16'hFFFF);       // R7 wrap
        apply(2, 8'h11, 8'h22, 0, 16'h4000);       // R7 imm16
        apply(0, 8'hAA, 8'hBB, 16'h1234, 16'h5678);// R8
        apply(7, 8'hAA, 8'hBB, 16'h1234, 16'h5678);// R8 reserved
        for (int k = 0; k < 300; k++) begin
            apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 65535)));
        end
        @(negedge clk);
        compare_prev();

        // R1 reset in mid-run clears outputs
        rst = 1'b1;
        mode = 3'd5;
        @(negedge clk);
        check("R1", "valid", int'(ea_valid), 0);
        check("R1", "addr", int'(ea_addr), 0);
        check("R1", "step", int'(pc_step), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule